// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Generator

This block raises the "transmit holding register empty" interrupt of a UART that has a 16-entry transmit FIFO. It watches the FIFO empty flag and the FIFO occupancy. It also sees the CPU strobes that write the holding register and read the interrupt identification register. From these it keeps one pending flag, and it gates that flag with two enable bits: the FIFO enable and the transmit interrupt enable.

When the FIFO empties, the interrupt does not always fire at once. If the FIFO has held two or more bytes at the same time since the last empty indication, the interrupt is raised on the next clock. If it has not, the block waits for one character time minus the final stop bit, counted in baud-clock enables, before it raises the interrupt. A CPU write during that wait cancels the delayed assertion. Changing the FIFO enable while the FIFO is empty raises the interrupt at once. The identification code goes to the chip's interrupt priority logic. There the code ranks with the ordinary holding-empty source, below every receive source.

Top module: `thre_irq_gen`

## Requirements
- R1: After reset, threIrq is 0 and irqId is 4'h1.
- R2: irqId is 4'h2 whenever threIrq is 1, and 4'h1 whenever threIrq is 0.
- R3: threIrq equals the internal pending flag ANDed with fifoEn and txIntEn. Clearing either enable hides a pending interrupt, and setting both enables again shows it.
- R4: A rising edge of txEmpty, seen at a clock edge when occupancy of two or more has been recorded since the last assertion, sets the pending flag at that same edge.
- R5: A rising edge of txEmpty with no such record arms a delay of (frameTicks - stopTicks) baud enables. The pending flag sets at the edge that samples the last of those baudTick pulses, and it stays clear before that.
- R6: A thrWrite clears the pending flag at that edge and cancels an armed delay. A write takes priority over any set event in the same cycle.
- R7: An iirRead clears the pending flag unless a set event happens in the same cycle.
- R8: A change of fifoEn, sampled while txEmpty is 1, sets the pending flag at that edge, with no delay.
- R9: The record of two or more bytes is set by any cycle with txCount >= 2 and cleared when the pending flag is set. After a burst-caused immediate interrupt, a later single-byte drain is delayed again.
- R10: When frameTicks <= stopTicks, the delay is zero and an empty edge sets the pending flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | FIFO enable bit |
| txIntEn | input | 1 | Transmit interrupt enable bit |
| txEmpty | input | 1 | Transmit FIFO empty flag |
| txCount | input | 5 | Transmit FIFO occupancy |
| thrWrite | input | 1 | CPU write strobe to the holding register |
| iirRead | input | 1 | CPU read strobe of the identification register |
| baudTick | input | 1 | Baud clock enable |
| frameTicks | input | 8 | Programmed character length in baud enables |
| stopTicks | input | 8 | Length of the final stop bit in baud enables |
| threIrq | output | 1 | Interrupt request |
| irqId | output | 4 | Identification code (2 = holding empty, 1 = none) |

## Verification
The assertions assume the following about the inputs:
- txEmpty is high exactly when txCount is zero.
- A write is never issued while the FIFO holds 16 bytes.
- The character length stays steady while a delay is armed.

The bench keeps to these rules by modelling the FIFO itself. It drives txCount and txEmpty from one counter that grows on each write, blocks a write when the counter is full, and drains at random. It changes frameTicks and stopTicks only between phases, at points where no delay can be armed.

// File: rtl/thre_pkg.sv
package thre_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadDelay;    // start the character-time delay
    logic cancelDelay;  // drop any armed delay
    logic clearWide;    // forget the two-or-more occupancy record
  } threStrobe_t;

  localparam logic [3:0] ID_THRE = 4'h2;
  localparam logic [3:0] ID_NONE = 4'h1;
endpackage

// File: rtl/thre_datapath.sv
module thre_datapath
  import thre_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TICK_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  threStrobe_t       strobe,
  input  logic              baudTick,
  input  logic [TICK_W-1:0] frameTicks,
  input  logic [TICK_W-1:0] stopTicks,
  input  logic [CNT_W-1:0]  txCount,
  output logic              delayDone,
  output logic              delayZero,
  output logic              wideSeen
);
  logic              armed;
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] delayLen;

  assign delayZero = (frameTicks <= stopTicks);
  assign delayLen  = frameTicks - stopTicks;
  assign delayDone = armed && baudTick && (cnt == TICK_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (strobe.cancelDelay) begin
      armed <= 1'b0;
    end else if (strobe.loadDelay) begin
      armed <= 1'b1;
      cnt   <= delayLen;
    end else if (armed && baudTick) begin
      if (cnt == TICK_W'(1)) armed <= 1'b0;
      else                   cnt   <= cnt - TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        wideSeen <= 1'b0;
    else if (txCount >= CNT_W'(2))    wideSeen <= 1'b1;
    else if (strobe.clearWide)        wideSeen <= 1'b0;
  end

  // R9
  wide_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount >= CNT_W'(2)) |=> wideSeen);
  // R5
  armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (cnt != '0));
  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cancelDelay |=> !armed);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !baudTick && !strobe.cancelDelay && !strobe.loadDelay) |=> (armed && $stable(cnt)));
endmodule

// File: rtl/thre_ctrl.sv
module thre_ctrl
  import thre_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoEn,
  input  logic        txEmpty,
  input  logic        thrWrite,
  input  logic        iirRead,
  input  logic        delayDone,
  input  logic        delayZero,
  input  logic        wideSeen,
  output threStrobe_t strobe,
  output logic        pendQ
);
  logic emptyPrev;
  logic fifoEnPrev;
  logic riseEmpty;
  logic enFlip;
  logic immSet;
  logic setEvt;

  assign riseEmpty = txEmpty && !emptyPrev;
  assign enFlip    = fifoEn ^ fifoEnPrev;
  assign immSet    = (riseEmpty && (wideSeen || delayZero)) || (enFlip && txEmpty);
  assign setEvt    = !thrWrite && (immSet || delayDone);

  always_comb begin
    strobe.loadDelay   = riseEmpty && !wideSeen && !delayZero && !thrWrite && !immSet;
    strobe.cancelDelay = thrWrite || immSet;
    strobe.clearWide   = setEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyPrev  <= 1'b1;
      fifoEnPrev <= 1'b0;
      pendQ      <= 1'b0;
    end else begin
      emptyPrev  <= txEmpty;
      fifoEnPrev <= fifoEn;
      if (thrWrite)     pendQ <= 1'b0;
      else if (setEvt)  pendQ <= 1'b1;
      else if (iirRead) pendQ <= 1'b0;
    end
  end

  // R6
  write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !pendQ);
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && !thrWrite && !setEvt) |=> !pendQ);
  // R4
  imm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseEmpty && wideSeen && !thrWrite) |=> pendQ);
  // R8
  flip_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enFlip && txEmpty && !thrWrite) |=> pendQ);
endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
  import thre_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TICK_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              txIntEn,
  input  logic              txEmpty,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              thrWrite,
  input  logic              iirRead,
  input  logic              baudTick,
  input  logic [TICK_W-1:0] frameTicks,
  input  logic [TICK_W-1:0] stopTicks,
  output logic              threIrq,
  output logic [3:0]        irqId
);
  threStrobe_t strobe;
  logic delayDone, delayZero, wideSeen, pendQ;

  thre_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txEmpty(txEmpty),
    .thrWrite(thrWrite), .iirRead(iirRead), .delayDone(delayDone),
    .delayZero(delayZero), .wideSeen(wideSeen), .strobe(strobe), .pendQ(pendQ)
  );

  thre_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .TICK_W(TICK_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baudTick(baudTick),
    .frameTicks(frameTicks), .stopTicks(stopTicks), .txCount(txCount),
    .delayDone(delayDone), .delayZero(delayZero), .wideSeen(wideSeen)
  );

  assign threIrq = pendQ && fifoEn && txIntEn;
  assign irqId   = threIrq ? ID_THRE : ID_NONE;
endmodule

// File: tb/tb_thre_irq_gen.sv
module tb_thre_irq_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0, txIntEn = 1'b1, txEmpty = 1'b1;
  logic [4:0] txCount = '0;
  logic thrWrite = 1'b0, iirRead = 1'b0, baudTick = 1'b0;
  logic [7:0] frameTicks = 8'd10, stopTicks = 8'd1;
  logic threIrq;
  logic [3:0] irqId;

  int checks = 0, failures = 0, fifoCnt = 0;
  bit done = 0;
  // reference state
  bit mPrevE = 1, mPrevEn = 0, mPend = 0, mWide = 0, mArmed = 0;
  int mCnt = 0;

  always #10 clk = ~clk;

  thre_irq_gen dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .txIntEn(txIntEn), .txEmpty(txEmpty),
    .txCount(txCount), .thrWrite(thrWrite), .iirRead(iirRead), .baudTick(baudTick),
    .frameTicks(frameTicks), .stopTicks(stopTicks), .threIrq(threIrq), .irqId(irqId)
  );

  function automatic int delayOf();
    return (frameTicks <= stopTicks) ? 0 : int'(frameTicks) - int'(stopTicks);
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit rise, flip, imm, dn, setE, load;
    int dly = delayOf();
    rise = txEmpty && !mPrevE;
    flip = fifoEn ^ mPrevEn;
    imm  = (rise && (mWide || dly == 0)) || (flip && txEmpty);
    dn   = mArmed && baudTick && mCnt == 1;
    setE = !thrWrite && (imm || dn);
    load = rise && !mWide && dly != 0 && !thrWrite && !imm;
    if (thrWrite || imm) mArmed = 0;
    else if (load) begin mArmed = 1; mCnt = dly; end
    else if (mArmed && baudTick) begin
      if (mCnt == 1) mArmed = 0; else mCnt--;
    end
    if (txCount >= 2) mWide = 1; else if (setE) mWide = 0;
    if (thrWrite) mPend = 0; else if (setE) mPend = 1; else if (iirRead) mPend = 0;
    mPrevE = txEmpty;
    mPrevEn = fifoEn;
  endtask

  task automatic step(input bit wr, input bit rd, input bit tick, input bit drain, input string tag);
    bit expIrq;
    @(negedge clk);
    thrWrite = wr && (fifoCnt < 16);
    iirRead  = rd;
    baudTick = tick;
    txCount  = 5'(fifoCnt);
    txEmpty  = (fifoCnt == 0);
    @(posedge clk);
    modelEdge();
    if (thrWrite) fifoCnt++;
    else if (drain && fifoCnt > 0) fifoCnt--;
    #1;
    expIrq = mPend && fifoEn && txIntEn;
    check({3'b0, threIrq}, {3'b0, expIrq}, tag);
    check(irqId, expIrq ? 4'h2 : 4'h1, "R2");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check({3'b0, threIrq}, 4'h0, "R1");
    check(irqId, 4'h1, "R1");
    @(negedge clk) rstN = 1'b1;
    step(0, 0, 0, 0, "R1");
    check({3'b0, threIrq}, 4'h0, "R1");

    fifoEn = 1'b1;                      // enable change while empty
    step(0, 0, 0, 0, "R8");
    check({3'b0, threIrq}, 4'h1, "R8");
    check(irqId, 4'h2, "R2");
    step(0, 1, 0, 0, "R7");
    check({3'b0, threIrq}, 4'h0, "R7");

    // single byte: delayed by 9 ticks
    step(1, 0, 0, 0, "R5");
    step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 0, "R5");             // empty edge seen, delay armed
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 1, 0, "R5");
      check({3'b0, threIrq}, 4'h0, "R5");
    end
    step(0, 0, 1, 0, "R5");
    check({3'b0, threIrq}, 4'h1, "R5");
    step(0, 1, 0, 0, "R7");

    // two bytes together: immediate
    step(1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, "R4");
    check({3'b0, threIrq}, 4'h1, "R4");
    step(0, 1, 0, 0, "R7");

    // record was cleared: single byte is delayed again
    step(1, 0, 0, 0, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    check({3'b0, threIrq}, 4'h0, "R9");
    step(1, 0, 0, 0, "R6");             // write cancels the delay
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0, "R6");
    check({3'b0, threIrq}, 4'h0, "R6");

    // R3 gating
    step(0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, "R3");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, "R3");
    check({3'b0, threIrq}, 4'h1, "R3");
    txIntEn = 1'b0;
    step(0, 0, 0, 0, "R3");
    check({3'b0, threIrq}, 4'h0, "R3");
    txIntEn = 1'b1;
    step(0, 0, 0, 0, "R3");
    check({3'b0, threIrq}, 4'h1, "R3");
    step(1, 0, 0, 0, "R6");
    check({3'b0, threIrq}, 4'h0, "R6");

    // zero delay
    stopTicks = 8'd10;
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, "R10");
    check({3'b0, threIrq}, 4'h1, "R10");
    step(0, 1, 0, 0, "R7");
    stopTicks = 8'd1;

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit wr, rd, tk, dr;
      wr = ($urandom % 100) < 12;
      rd = ($urandom % 100) < 6;
      tk = ($urandom % 100) < 40;
      dr = ($urandom % 100) < 30;
      if (($urandom % 500) == 0) fifoEn = ~fifoEn;
      if (($urandom % 300) == 0) txIntEn = ~txIntEn;
      step(wr, rd, tk, dr, "R5 random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule